// File: doc/BRIEF.md
# Block-Lock Write Guard for a Serial Memory Array

This block rules on every nonvolatile write that a serial memory controller wants to make into a 32768-byte array of 64-byte pages. It keeps a small protection register in flip-flops. The register holds a software arm bit, a three-bit lock code and a pin-gated freeze enable. For each request it returns a combinational grant. The controller commits the write only when the grant is high. Address 0xFFFF does not reach the array. A write there updates the protection register instead, and a copy of that register is always on the output port.

The arm bit is tracked by a two-state machine. **S_SAFE** means the arm bit is clear: array writes are refused and the lock fields are frozen. **S_ARMED** means the arm bit is set: array writes outside the locked region are allowed, and the lock fields may be reloaded. There are three named transitions:
- **ARM** (S_SAFE to S_ARMED): a register write whose bit 0 is 1.
- **LOAD** (S_ARMED to S_ARMED): a register write whose bit 0 is 1. It replaces the lock code and the freeze enable.
- **DISARM** (S_ARMED to S_SAFE): a register write whose bit 0 is 0.

Any other request leaves the machine where it is.

Top module: `blocklock_guard`

## Requirements
- R1: After reset the register reads 0 (`reg_q` = 5'b00000) and the machine is in S_SAFE.
- R2: While the arm bit (`reg_q[0]`) is 0, every array write request is denied.
- R3: In S_SAFE, a register write with data bit 0 set is granted. It sets only the arm bit and leaves `reg_q[4:1]` unchanged (ARM).
- R4: In S_SAFE, a register write with data bit 0 clear is denied and changes nothing.
- R5: In S_ARMED with no freeze, a register write with bit 0 set is granted. It loads `reg_q[3:1]` from data bits 3:1 and `reg_q[4]` from data bit 4 (LOAD). A register write with bit 0 clear is granted, clears only the arm bit and leaves `reg_q[4:1]` unchanged (DISARM).
- R6: The lock code in `reg_q[3:1]` protects a region that starts at page 0. The codes map as follows:
  - 0: nothing protected
  - 1: 1 page
  - 2: 2 pages
  - 3: 4 pages
  - 4: 8 pages
  - 5: 128 pages (byte addresses up to 0x1FFF)
  - 6: 256 pages (up to 0x3FFF)
  - 7: all 512 pages
  
  An array write is granted exactly when the arm bit is 1 and the page lies outside that region.
- R7: The lock check uses the page of the given start address (address bits 14:6). With code 1, address 0x003F is denied and 0x0040 is granted.
- R8: When `reg_q[4]` is 1 and `wp_pin` is 1, a LOAD request is denied and the lock code and the freeze enable stay unchanged.
- R9: When `wp_pin` is 0 or `reg_q[4]` is 0, LOAD is granted even while a region is locked.
- R10: The grant is 0 whenever `wr_req` is 0. An array write, granted or not, never changes `reg_q`.
- R11: Only address 0xFFFF selects the register. Every other 16-bit address is an array write to its low 15 bits, so bit 15 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | A write is requested this cycle |
| wr_addr | input | 16 | Target address; 0xFFFF is the protection register |
| wr_data | input | 5 | Register data: bit 0 arm, bits 3:1 lock code, bit 4 freeze enable |
| wp_pin | input | 1 | Write-protect pin; together with `reg_q[4]` it freezes the lock fields |
| grant | output | 1 | Combinational permission for the current request |
| reg_q | output | 5 | Current protection register, same bit layout as `wr_data` |

## Verification
A wrong machine state appears at once on `reg_q[0]`. It also shows in the same cycle on `grant`, for both array requests and register requests. A corrupted lock code appears on `reg_q[3:1]` in the cycle after the bad update. It then shows as a grant that flips at a page boundary. The register copy and the grant are therefore compared against a behavioural model on every cycle, so a divergence is caught within one cycle of the step that caused it. Directed steps sit at the region edges and around the frozen and aliased-address cases.

// File: rtl/blocklock_guard_pkg.sv
package blocklock_guard_pkg;

    typedef enum logic {
        S_SAFE  = 1'b0,
        S_ARMED = 1'b1
    } guard_state_t;

    localparam int REG_W    = 5;
    localparam int B_ARM    = 0;
    localparam int B_LOCK_L = 1;
    localparam int B_LOCK_H = 3;
    localparam int B_FREEZE = 4;

endpackage

// File: rtl/blocklock_region.sv
module blocklock_region #(
    parameter int ARR_AW  = 15,
    parameter int PAGE_AW = 6
) (
    input  logic [ARR_AW-1:0] byte_addr,
    input  logic [2:0]        lock_code,
    output logic              in_region
);
    localparam int PAGE_W    = ARR_AW - PAGE_AW;
    localparam int N_PAGES   = 1 << PAGE_W;
    localparam int LIM_W     = PAGE_W + 1;

    logic [PAGE_W-1:0] page;
    logic [LIM_W-1:0]  limit;

    assign page = byte_addr[ARR_AW-1:PAGE_AW];

    always_comb begin
        unique case (lock_code)
            3'd0:    limit = '0;
            3'd1:    limit = LIM_W'(1);
            3'd2:    limit = LIM_W'(2);
            3'd3:    limit = LIM_W'(4);
            3'd4:    limit = LIM_W'(8);
            3'd5:    limit = LIM_W'(N_PAGES / 4);
            3'd6:    limit = LIM_W'(N_PAGES / 2);
            default: limit = LIM_W'(N_PAGES);
        endcase
    end

    assign in_region = ({1'b0, page} < limit);

endmodule

// File: rtl/blocklock_fsm.sv
module blocklock_fsm
    import blocklock_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_req,
    input  logic [REG_W-1:0] reg_data,
    input  logic             wp_pin,
    output logic             reg_grant,
    output guard_state_t     state,
    output logic [2:0]       lock_code,
    output logic             freeze_en
);
    guard_state_t state_nx;
    logic [2:0]   lock_nx;
    logic         freeze_nx;
    logic         frozen;

    assign frozen = freeze_en & wp_pin;

    // grant and next-state decision
    always_comb begin
        state_nx  = state;
        lock_nx   = lock_code;
        freeze_nx = freeze_en;
        reg_grant = 1'b0;
        unique case (state)
            S_SAFE: begin
                if (reg_req && reg_data[B_ARM]) begin
                    reg_grant = 1'b1;
                    state_nx  = S_ARMED;
                end
            end
            S_ARMED: begin
                if (reg_req) begin
                    if (!reg_data[B_ARM]) begin
                        reg_grant = 1'b1;
                        state_nx  = S_SAFE;
                    end else if (!frozen) begin
                        reg_grant = 1'b1;
                        lock_nx   = reg_data[B_LOCK_H:B_LOCK_L];
                        freeze_nx = reg_data[B_FREEZE];
                    end
                end
            end
            default: state_nx = S_SAFE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_SAFE;
            lock_code <= '0;
            freeze_en <= 1'b0;
        end else begin
            state     <= state_nx;
            lock_code <= lock_nx;
            freeze_en <= freeze_nx;
        end
    end

    // R4
    safe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SAFE) |=> ($stable(lock_code) && $stable(freeze_en)));

    // R8
    frozen_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && state == S_ARMED && freeze_en && wp_pin)
        |=> ($stable(lock_code) && $stable(freeze_en)));

    // R3
    arm_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && state == S_SAFE && reg_data[B_ARM])
        |=> (state == S_ARMED && $stable(lock_code)));

endmodule

// File: rtl/blocklock_guard.sv
module blocklock_guard
    import blocklock_guard_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ARR_AW  = 15,
    parameter int PAGE_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              wp_pin,
    output logic              grant,
    output logic [REG_W-1:0]  reg_q
);
    localparam logic [ADDR_W-1:0] REG_ADDR = '1;

    logic         is_reg;
    logic         in_region;
    logic         reg_grant;
    logic         arr_grant;
    guard_state_t state;
    logic [2:0]   lock_code;
    logic         freeze_en;
    logic         armed;

    assign is_reg = (wr_addr == REG_ADDR);
    assign armed  = (state == S_ARMED);

    blocklock_region #(
        .ARR_AW  (ARR_AW),
        .PAGE_AW (PAGE_AW)
    ) u_region (
        .byte_addr (wr_addr[ARR_AW-1:0]),
        .lock_code (lock_code),
        .in_region (in_region)
    );

    blocklock_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_req   (wr_req & is_reg),
        .reg_data  (wr_data),
        .wp_pin    (wp_pin),
        .reg_grant (reg_grant),
        .state     (state),
        .lock_code (lock_code),
        .freeze_en (freeze_en)
    );

    assign arr_grant = wr_req & ~is_reg & armed & ~in_region;
    assign grant     = is_reg ? reg_grant : arr_grant;

    always_comb begin
        reg_q           = '0;
        reg_q[B_ARM]    = armed;
        reg_q[B_LOCK_H:B_LOCK_L] = lock_code;
        reg_q[B_FREEZE] = freeze_en;
    end

    // R10
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |-> !grant);

    // R10
    array_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !is_reg) |=> $stable(reg_q));

    // R2
    unarmed_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !is_reg && !reg_q[B_ARM]) |-> !grant);

    // R6
    full_lock_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !is_reg && reg_q[B_LOCK_H:B_LOCK_L] == 3'd7) |-> !grant);

endmodule

// File: tb/blocklock_guard_bench.sv
module blocklock_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [4:0]  wr_data = '0;
    logic        wp_pin = 1'b0;
    logic        grant;
    logic [4:0]  reg_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    bit m_arm = 0;
    int m_lock = 0;
    bit m_frz = 0;

    always #4 clk = ~clk;

    blocklock_guard u_blocklock_guard (
        .clk (clk), .rst_n (rst_n), .wr_req (wr_req), .wr_addr (wr_addr),
        .wr_data (wr_data), .wp_pin (wp_pin), .grant (grant), .reg_q (reg_q)
    );

    function automatic int pages_locked(int code);
        int tbl [8] = '{0, 1, 2, 4, 8, 128, 256, 512};
        return tbl[code];
    endfunction

    function automatic bit model_grant(bit req, int addr, int data, bit wp);
        if (!req) return 0;
        if (addr == 16'hFFFF) begin
            if (!m_arm) return data[0];
            if (!data[0]) return 1;
            return !(m_frz && wp);
        end
        return m_arm && (((addr & 16'h7FFF) / 64) >= pages_locked(m_lock));
    endfunction

    function automatic int model_reg();
        return (int'(m_frz) * 16) + (m_lock * 2) + int'(m_arm);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit req, int addr, int data, bit wp, string tag);
        bit g;
        @(negedge clk);
        wr_req = req; wr_addr = addr[15:0]; wr_data = data[4:0]; wp_pin = wp;
        #1;
        g = model_grant(req, addr, data, wp);
        check(tag, int'(grant), int'(g), "grant");
        check(tag, int'(reg_q), model_reg(), "reg_q");
        if (req && g && addr == 16'hFFFF) begin
            if (!m_arm) m_arm = 1;
            else if (!data[0]) m_arm = 0;
            else begin m_lock = (data >> 1) & 7; m_frz = data[4]; end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", int'(reg_q), 0, "reset register");
        rst_n = 1'b1;
        step(0, 16'hFFFF, 5'h1F, 0, "R10");
        step(1, 16'h0100, 0, 0, "R2");
        step(1, 16'hFFFF, 5'h00, 0, "R4");
        step(1, 16'hFFFF, 5'h1E, 0, "R4");
        step(1, 16'hFFFF, 5'h01, 0, "R3");
        step(1, 16'hFFFF, 5'h13, 0, "R5");
        step(1, 16'h003F, 0, 0, "R7");
        step(1, 16'h0040, 0, 0, "R7");
        step(1, 16'h8000, 0, 0, "R11");
        step(1, 16'h8040, 0, 1, "R11");
        step(1, 16'hFFFE, 0, 1, "R11");
        step(1, 16'hFFFF, 5'h0F, 1, "R8");
        step(1, 16'h0040, 0, 1, "R8");
        step(1, 16'hFFFF, 5'h1F, 0, "R9");
        step(1, 16'h7FFF, 0, 0, "R6");
        step(1, 16'hFFFF, 5'h0B, 0, "R9");
        step(1, 16'h1FFF, 0, 0, "R6");
        step(1, 16'h2000, 0, 0, "R6");
        step(1, 16'hFFFF, 5'h00, 1, "R5");
        step(1, 16'h7000, 0, 0, "R2");
        step(1, 16'hFFFF, 5'h01, 0, "R3");
        for (int code = 0; code < 8; code++) begin
            step(1, 16'hFFFF, (code * 2) + 1, 0, "R5");
            step(1, (pages_locked(code) > 0 ? pages_locked(code) - 1 : 0) * 64, 0, 0, "R6");
            step(1, pages_locked(code) * 64 + 63, 0, 0, "R6");
        end
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            int a = (sel < 3) ? 16'hFFFF : (sel < 7 ? $urandom_range(0, 16'h07FF) : $urandom_range(0, 16'hFFFF));
            string tg = (a == 16'hFFFF) ? (m_arm ? "R5" : "R3") : (m_arm ? "R6" : "R2");
            step($urandom_range(0, 7) != 0, a, $urandom_range(0, 31), $urandom_range(0, 1), tg);
        end
        step(0, 0, 0, 0, "R10");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule